// File: doc/BRIEF.md
# Multi-Byte SPI Master Controller

This block is a single-master SPI controller. A one-cycle start pulse launches one transfer of one to four bytes. The clock mode, the byte count, the slave-select pattern and the transmit word are taken from parallel inputs and held for the whole transfer. The block shifts the transmit word out on `mosi`, most significant bit first, and shifts `miso` into a receive register. At the end it presents the received bits on `rx_word`, zero-extended to 32 bits.

The serial clock rate comes from a free-running down-counter. The counter reloads itself from the `div_val` input each time it reaches zero, and it raises a strobe while it holds zero. A control state machine has four states. Idle (code 0) waits for start. Prepare (code 1) holds the select lines low and waits for the next strobe. Transfer (code 2) toggles the serial clock on every strobe until all edges are issued. Done (code 3) commits the received data. The transitions are:

- Idle→Prepare on start.
- Prepare→Transfer on a strobe.
- Transfer→Done on the strobe that issues the final edge.
- Done→Idle unconditionally.

The strobe, the edge enable and the state code are brought out for test.

Top module: `spi_xfer_master`

## Requirements
- R1: The strobe `tick_test` is high exactly while the internal down-counter is zero. At zero, the counter loads `div_val` on the next clock; otherwise it decrements. With a steady `div_val` of d, strobes therefore recur every d+1 clocks.
- R2: An asynchronous active-low `rst_n` clears all state. During and right after reset:
  - `busy`=0, `ss_n`=all ones, `rx_word`=0, `sclk`=0 and `state_test`=0.
  - The strobe counter is 0, so `tick_test`=1 until the first clock edge.
- R3: `len_code` values 0, 1, 2 and 3 select 1, 2, 3 and 4 bytes. A transfer of n bits produces exactly 2n serial-clock edges.
- R4: `mosi` sends bits 8·(len_code+1)−1 down to 0 of the `tx_word` latched at start, most significant first.
- R5: `mode[1]` is the clock polarity, which is the idle level of `sclk`. `mode[0]` is the phase:
  - With phase 0, both sides sample on the first edge of each bit.
  - With phase 1, both sides sample on the second edge of each bit.
- R6: At the end of a transfer, `rx_word` holds the n received bits in its low n bits, the last received bit at bit 0, and all upper bits 0. It changes at no other time.
- R7: `ss_n` equals the bitwise inverse of the `sel_mask` latched at start for the whole time `busy` is high. It is all ones whenever `busy` is low.
- R8: In idle, a start pulse makes `busy` rise on the next clock. A start pulse while `busy` is high is ignored, and so is any change of `tx_word` during that time.
- R9: `state_test` shows the state codes 0 (idle), 1 (prepare), 2 (transfer) and 3 (done). The sequence is 0→1→2→3→0, and state 3 lasts one clock, after which `busy` is low.
- R10: `sclk` changes only on cycles where the strobe is high in the transfer state. Consecutive edges are div+1 clocks apart, so `div_val`=0 runs `sclk` at half the system clock.
- R11: `en_test` is high on exactly the cycles whose clock edge toggles `sclk`. It is high 2n times per transfer and only while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a transfer when idle |
| div_val | input | 8 | Strobe counter reload value; the strobe period is div_val+1 clocks |
| sel_mask | input | 8 | Lines to drive low during the transfer (1 = selected) |
| len_code | input | 2 | Byte count minus one |
| mode | input | 2 | Bit 1 clock polarity, bit 0 clock phase |
| tx_word | input | 32 | Transmit word; the low 8·(len_code+1) bits are sent |
| miso | input | 1 | Serial data from the slave |
| busy | output | 1 | High from the clock after start until the transfer completes |
| rx_word | output | 32 | Received data, zero-extended |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| ss_n | output | 8 | Active-low slave selects |
| tick_test | output | 1 | Timing strobe, for test |
| en_test | output | 1 | Serial-clock toggle enable, for test |
| state_test | output | 3 | Control state code, for test |

## Verification
The strobe assertions assume `div_val` does not change between a strobe and the following clock. The serial-clock assertions assume the caller keeps `div_val` and `mode` steady from two clocks before start until `busy` falls. The bench only reprograms these inputs while the block is idle and then waits two clocks before pulsing start. It drives a phase-aware slave model that presents data on the non-sampling edge. The one deliberate start pulse during a transfer also rewrites `tx_word`, to show that the latched word is kept.

// File: rtl/spim_pkg.sv
package spim_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PREP = 3'd1,
        ST_XFER = 3'd2,
        ST_DONE = 3'd3
    } spim_state_e;

endpackage

// File: rtl/spim_tick.sv
// Self-reloading down-counter; the strobe is high while the count is zero.
module spim_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == '0)
            cnt_q <= div_val;
        else
            cnt_q <= cnt_q - DIV_W'(1);
    end

    assign tick = (cnt_q == '0);
endmodule

// File: rtl/spim_sclk.sv
// Serial clock register: follows the idle level while parked, toggles on demand.
module spim_sclk (
    input  logic clk,
    input  logic rst_n,
    input  logic park,
    input  logic idle_lvl,
    input  logic toggle,
    output logic sclk
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sclk <= 1'b0;
        else if (park)
            sclk <= idle_lvl;
        else if (toggle)
            sclk <= ~sclk;
    end
endmodule

// File: rtl/spim_shreg.sv
// Transmit and receive shift registers with length-dependent output masking.
module spim_shreg #(
    parameter int BYTES = 4,
    localparam int DATA_W = 8 * BYTES,
    localparam int LEN_W  = $clog2(BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_in,
    input  logic [LEN_W-1:0]  len,
    input  logic              shift_tx,
    input  logic              sample,
    input  logic              miso,
    input  logic              commit,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_word
);
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;
    logic [DATA_W-1:0] keep;

    for (genvar b = 0; b < BYTES; b++) begin : g_keep
        assign keep[b*8 +: 8] = (int'(len) >= b) ? 8'hFF : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            rx_word <= '0;
        end else begin
            if (load) begin
                tx_sr <= tx_in;
                rx_sr <= '0;
            end else begin
                if (shift_tx)
                    tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
                if (sample)
                    rx_sr <= {rx_sr[DATA_W-2:0], miso};
            end
            if (commit)
                rx_word <= rx_sr & keep;
        end
    end

    // Top bit of the active window: 8*len + 7
    assign mosi = tx_sr[{len, 3'b111}];
endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
    parameter int DIV_W = 8,
    parameter int SEL_W = 8,
    parameter int BYTES = 4,
    localparam int DATA_W = 8 * BYTES,
    localparam int LEN_W  = $clog2(BYTES),
    localparam int EDGE_W = $clog2(2 * DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIV_W-1:0]  div_val,
    input  logic [SEL_W-1:0]  sel_mask,
    input  logic [LEN_W-1:0]  len_code,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic [DATA_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic [SEL_W-1:0]  ss_n,
    output logic              tick_test,
    output logic              en_test,
    output logic [2:0]        state_test
);
    import spim_pkg::*;

    spim_state_e       state_q, state_d;
    logic              cpol_q, cpha_q;
    logic [LEN_W-1:0]  len_q;
    logic [SEL_W-1:0]  sel_q;
    logic [EDGE_W-1:0] edge_q;
    logic [EDGE_W-1:0] last_edge;
    logic              tick;
    logic              load, step, sample_now, shift_now, commit, lead;

    spim_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_val (div_val),
        .tick    (tick)
    );

    assign last_edge = EDGE_W'(16 * (int'(len_q) + 1) - 1);
    assign lead      = ~edge_q[0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)                      state_d = ST_PREP;
            ST_PREP: if (tick)                       state_d = ST_XFER;
            ST_XFER: if (tick && edge_q == last_edge) state_d = ST_DONE;
            ST_DONE:                                 state_d = ST_IDLE;
            default:                                 state_d = ST_IDLE;
        endcase
    end

    // Output and control decode
    always_comb begin
        busy       = (state_q != ST_IDLE);
        load       = (state_q == ST_IDLE) && start;
        step       = (state_q == ST_XFER) && tick;
        commit     = (state_q == ST_DONE);
        sample_now = step && (lead ^ cpha_q);
        shift_now  = step && !(lead ^ cpha_q) && (edge_q != '0);
        ss_n       = busy ? ~sel_q : '1;
    end

    // Configuration latch and edge counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpol_q <= 1'b0;
            cpha_q <= 1'b0;
            len_q  <= '0;
            sel_q  <= '0;
            edge_q <= '0;
        end else if (load) begin
            cpol_q <= mode[1];
            cpha_q <= mode[0];
            len_q  <= len_code;
            sel_q  <= sel_mask;
            edge_q <= '0;
        end else if (step) begin
            edge_q <= edge_q + EDGE_W'(1);
        end
    end

    spim_sclk u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .park     (state_q == ST_IDLE),
        .idle_lvl (mode[1]),
        .toggle   (step),
        .sclk     (sclk)
    );

    spim_shreg #(.BYTES(BYTES)) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .tx_in    (tx_word),
        .len      (load ? len_code : len_q),
        .shift_tx (shift_now),
        .sample   (sample_now),
        .miso     (miso),
        .commit   (commit),
        .mosi     (mosi),
        .rx_word  (rx_word)
    );

    assign tick_test  = tick;
    assign en_test    = step;
    assign state_test = state_q;

    logic unused_cpol;
    assign unused_cpol = cpol_q;
endmodule

// File: rtl/spi_xfer_master_chk.sv
module spi_xfer_master_chk #(
    parameter int DIV_W = 8,
    parameter int SEL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic [SEL_W-1:0] ss_n,
    input logic             sclk,
    input logic             tick_test,
    input logic             en_test,
    input logic [2:0]       state_test,
    input logic [DIV_W-1:0] div_val
);
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n) tick_test && div_val != '0 |=> !tick_test); // R1
    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> ss_n == '1); // R7
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> $stable(ss_n)); // R7
    AST_START_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) !busy && start |=> busy && state_test == 3'd1); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) state_test == 3'd3 |=> state_test == 3'd0 && !busy); // R9
    AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) state_test <= 3'd3); // R9
    AST_SCLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) busy && !en_test |=> $stable(sclk)); // R10
    AST_DIV0_RATE: assert property (@(posedge clk) disable iff (!rst_n) tick_test && div_val == '0 |=> tick_test); // R10
    AST_EN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) en_test |-> tick_test && busy); // R11
endmodule

bind spi_xfer_master spi_xfer_master_chk #(.DIV_W(DIV_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .ss_n       (ss_n),
    .sclk       (sclk),
    .tick_test  (tick_test),
    .en_test    (en_test),
    .state_test (state_test),
    .div_val    (div_val)
);

// File: tb/spi_xfer_master_test.sv
`timescale 1ns/1ps
module spi_xfer_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  div_val = 8'd0;
    logic [7:0]  sel_mask = 8'd0;
    logic [1:0]  len_code = 2'd0;
    logic [1:0]  mode = 2'd0;
    logic [31:0] tx_word = 32'd0;
    logic        miso;
    logic        busy, sclk, mosi, tick_test, en_test;
    logic [31:0] rx_word;
    logic [7:0]  ss_n;
    logic [2:0]  state_test;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // slave model configuration (written by the tasks before arming)
    logic        s_cpol, s_cpha;
    int          s_nb;
    logic [31:0] s_word;
    logic        xfer_on = 1'b0;
    // slave model state (written only by the slave process)
    logic        armed = 1'b0;
    int          sidx, edges, first_cyc, last_cyc;
    logic [31:0] slave_rx;
    logic        miso_r = 1'b0;

    assign miso = miso_r;

    always #2.5 clk = ~clk;
    always @(negedge clk) cyc <= cyc + 1;

    spi_xfer_master uut (
        .clk(clk), .rst_n(rst_n), .start(start), .div_val(div_val),
        .sel_mask(sel_mask), .len_code(len_code), .mode(mode), .tx_word(tx_word),
        .miso(miso), .busy(busy), .rx_word(rx_word), .sclk(sclk), .mosi(mosi),
        .ss_n(ss_n), .tick_test(tick_test), .en_test(en_test), .state_test(state_test)
    );

    // Phase-aware slave: presents data on the non-sampling edge, samples on the other
    always @(sclk or posedge xfer_on or negedge xfer_on) begin
        if (!xfer_on) begin
            armed = 1'b0;
        end else if (!armed) begin
            armed    = 1'b1;
            edges    = 0;
            slave_rx = 32'd0;
            if (!s_cpha) begin
                miso_r = s_word[s_nb-1];
                sidx   = 1;
            end else begin
                miso_r = 1'b0;
                sidx   = 0;
            end
        end else begin
            edges = edges + 1;
            if (edges == 1) first_cyc = cyc;
            last_cyc = cyc;
            if ((sclk != s_cpol) ^ s_cpha)
                slave_rx = {slave_rx[30:0], mosi};
            else if (sidx < s_nb) begin
                miso_r = s_word[s_nb-1-sidx];
                sidx   = sidx + 1;
            end
        end
    end

    function automatic logic [31:0] len_mask(input int l);
        return (l >= 3) ? 32'hFFFF_FFFF : ((32'd1 << (8 * (l + 1))) - 32'd1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic tick_period(input logic [7:0] d);
        int last = -1;
        int seen = 0;
        @(negedge clk);
        div_val = d;
        for (int i = 0; i < 12 * (int'(d) + 1) + 4; i++) begin
            @(negedge clk);
            if (tick_test) begin
                seen++;
                if (seen >= 3)
                    chk((cyc - last) == int'(d) + 1, "R1 strobe period", 32'(cyc - last), 32'(int'(d) + 1));
                last = cyc;
            end
        end
    endtask

    task automatic run_xfer(input logic [1:0] l, input logic [1:0] m, input logic [7:0] d,
                            input logic [7:0] sel, input logic [31:0] tx, input logic [31:0] sw,
                            input bit poke);
        int nb = 8 * (int'(l) + 1);
        int cycles = 0;
        int ss_bad = 0;
        int en_cnt = 0;
        bit seen2 = 0;
        bit seen3 = 0;
        @(negedge clk);
        len_code = l; mode = m; div_val = d; sel_mask = sel; tx_word = tx;
        s_cpol = m[1]; s_cpha = m[0]; s_nb = nb; s_word = sw;
        @(negedge clk);
        @(negedge clk);
        xfer_on = 1'b1;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && state_test == 3'd1, "R8/R9 entry to prepare", {28'd0, busy, state_test}, 32'h9);
        while (busy && cycles < 5000) begin
            if (poke && cycles == 3) begin
                start = 1'b1;
                tx_word = ~tx;
            end else begin
                start = 1'b0;
            end
            if (ss_n != ~sel) ss_bad++;
            if (state_test == 3'd2) seen2 = 1;
            if (state_test == 3'd3) seen3 = 1;
            if (en_test) en_cnt++;
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        xfer_on = 1'b0;
        chk(rx_word == (sw & len_mask(int'(l))), "R6 rx zero-extended", rx_word, sw & len_mask(int'(l)));
        chk((slave_rx & len_mask(int'(l))) == (tx & len_mask(int'(l))), "R4 mosi stream",
            slave_rx & len_mask(int'(l)), tx & len_mask(int'(l)));
        chk(edges == 2 * nb, "R3 edge count", 32'(edges), 32'(2 * nb));
        chk(en_cnt == 2 * nb, "R11 enable count", 32'(en_cnt), 32'(2 * nb));
        chk(sclk == m[1], "R5 sclk idle level", {31'd0, sclk}, {31'd0, m[1]});
        chk(ss_bad == 0 && ss_n == 8'hFF, "R7 select lines", 32'(ss_bad), 32'd0);
        chk(seen2 && seen3 && state_test == 3'd0, "R9 state sequence", {29'd0, seen2, seen3, 1'b0}, 32'h6);
        chk((last_cyc - first_cyc) == (2 * nb - 1) * (int'(d) + 1), "R10 sclk rate",
            32'(last_cyc - first_cyc), 32'((2 * nb - 1) * (int'(d) + 1)));
        @(negedge clk);
        @(negedge clk);
        chk(!busy, "R8 start during busy ignored", {31'd0, busy}, 32'd0);
        tx_word = tx;
    endtask

    initial begin
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        repeat (3) @(negedge clk);
        chk(!busy && ss_n == 8'hFF && rx_word == 0 && !sclk && state_test == 0, "R2 reset state",
            {busy, ss_n, sclk, state_test}, {1'b0, 8'hFF, 1'b0, 3'd0});
        rst_n = 1'b1;
        chk(tick_test, "R2 strobe after reset", {31'd0, tick_test}, 32'd1);

        tick_period(8'd0);
        tick_period(8'd3);
        tick_period(8'd6);

        // directed: all modes, shortest and longest length, fastest clock
        for (int m = 0; m < 4; m++) begin
            run_xfer(2'd0, 2'(m), 8'd0, 8'h01, 32'h0000_00A5, 32'h0000_003C, 1'b0);
            run_xfer(2'd3, 2'(m), 8'd0, 8'h80, 32'h8421_C3F0, 32'hF00D_1E55, 1'b0);
        end
        run_xfer(2'd1, 2'd3, 8'd4, 8'h24, 32'hFFFF_84A8, 32'hFFFF_FFFF, 1'b1); // R8 poke
        run_xfer(2'd2, 2'd1, 8'd2, 8'hFF, 32'h00AB_CDEF, 32'h0012_3456, 1'b1);

        for (int k = 0; k < 20; k++) begin
            run_xfer(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                     8'($urandom_range(1, 255)), $urandom, $urandom, 1'b0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule